// File: doc/BRIEF.md
# Conditional Channel Accumulator

This block keeps a running sum that is fed and read through six handshaked channels. Each pass starts by taking one single-bit token from each of three control channels: take-A, take-B and emit. Then, and only when the matching control bit is 1, it takes one data token from operand channel A and/or operand channel B. It adds what it received to the running sum and, only when the emit bit is 1, offers the updated sum as one token on the result channel.

Every channel uses a valid/ready pair. A token moves on a rising clock edge where both valid and ready are high. A pass waits for as long as any transfer it needs has not happened, so a slow producer or consumer stalls the loop without losing data. The addition wraps modulo 2^WIDTH.

Top module: `cond_accum`

## Requirements
- R1: After reset the running sum is 0, so the first emitted result equals the sum of the operands taken since reset. In the idle reset state all three control readies are 1, both operand readies are 0 and res_valid is 0.
- R2: Each pass takes exactly one token from each of tka, tkb and emt, in whatever order they arrive. A control bit value of 1 means true. A control channel's ready drops once its token is taken and stays low until the pass ends.
- R3: When the take-A bit is 0, opa_ready stays 0 for the whole pass, no opa token is consumed, and operand A counts as 0. When the bit is 1, exactly one opa token is consumed.
- R4: When the take-B bit is 0, opb_ready stays 0 for the whole pass, no opb token is consumed, and operand B counts as 0. When the bit is 1, exactly one opb token is consumed.
- R5: No operand ready is raised before all three control tokens of the pass have been taken. The two operand transfers may complete in either order, and the sum update waits for both.
- R6: The sum becomes (sum + A + B) mod 2^WIDTH once per pass, after the operand transfers.
- R7: When the emit bit is 1, exactly one result token carrying the updated sum is produced. When it is 0, no result token is produced in that pass.
- R8: While res_valid is 1 and res_ready is 0, res_valid and res_data hold steady and no control token of the next pass is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tka_valid | input | 1 | Take-A control token offered |
| tka_ready | output | 1 | Take-A control token accepted this edge |
| tka_bit | input | 1 | 1: consume an operand A token this pass |
| tkb_valid | input | 1 | Take-B control token offered |
| tkb_ready | output | 1 | Take-B control token accepted this edge |
| tkb_bit | input | 1 | 1: consume an operand B token this pass |
| emt_valid | input | 1 | Emit control token offered |
| emt_ready | output | 1 | Emit control token accepted this edge |
| emt_bit | input | 1 | 1: send the updated sum this pass |
| opa_valid | input | 1 | Operand A token offered |
| opa_ready | output | 1 | Operand A token accepted this edge |
| opa_data | input | WIDTH | Operand A value |
| opb_valid | input | 1 | Operand B token offered |
| opb_ready | output | 1 | Operand B token accepted this edge |
| opb_data | input | WIDTH | Operand B value |
| res_valid | output | 1 | Result token offered |
| res_ready | input | 1 | Consumer takes the result this edge |
| res_data | output | WIDTH | Updated running sum |

## Verification
A corrupted sum register does not show at once. It appears only at the next pass whose emit bit is 1, so the bench emits often and compares every result with its own model. A wrong flag or state shows up faster, usually within the same pass. An operand ready that rises while its control bit is 0 would swallow a poison token that the bench offers on purpose. A control ready that rises during a stalled result would let the next pass start early. A pass that never finishes would leave ready or valid stuck, which the per-pass timeout reports.

// File: rtl/cond_accum.sv
`timescale 1ns/1ps
module cond_accum #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tka_valid,
  output logic             tka_ready,
  input  logic             tka_bit,
  input  logic             tkb_valid,
  output logic             tkb_ready,
  input  logic             tkb_bit,
  input  logic             emt_valid,
  output logic             emt_ready,
  input  logic             emt_bit,
  input  logic             opa_valid,
  output logic             opa_ready,
  input  logic [WIDTH-1:0] opa_data,
  input  logic             opb_valid,
  output logic             opb_ready,
  input  logic [WIDTH-1:0] opb_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [WIDTH-1:0] res_data
);

  typedef enum logic [1:0] {ST_CTRL, ST_DATA, ST_ADD, ST_SEND} state_t;

  state_t           st;
  logic [2:0]       got_c;
  logic [2:0]       cbits;
  logic [1:0]       got_x;
  logic [WIDTH-1:0] va, vb, acc;

  logic [2:0] cfire;
  logic       afire, bfire, rfire, a_ok, b_ok;

  assign tka_ready = (st == ST_CTRL) && !got_c[0];
  assign tkb_ready = (st == ST_CTRL) && !got_c[1];
  assign emt_ready = (st == ST_CTRL) && !got_c[2];
  assign opa_ready = (st == ST_DATA) && cbits[0] && !got_x[0];
  assign opb_ready = (st == ST_DATA) && cbits[1] && !got_x[1];
  assign res_valid = (st == ST_SEND);
  assign res_data  = acc;

  assign cfire = {emt_valid & emt_ready, tkb_valid & tkb_ready, tka_valid & tka_ready};
  assign afire = opa_valid & opa_ready;
  assign bfire = opb_valid & opb_ready;
  assign rfire = res_valid & res_ready;
  assign a_ok  = !cbits[0] || got_x[0] || afire;
  assign b_ok  = !cbits[1] || got_x[1] || bfire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_CTRL;
      got_c <= '0;
      cbits <= '0;
      got_x <= '0;
      va    <= '0;
      vb    <= '0;
      acc   <= '0;
    end else begin
      case (st)
        ST_CTRL: begin
          if (cfire[0]) cbits[0] <= tka_bit;
          if (cfire[1]) cbits[1] <= tkb_bit;
          if (cfire[2]) cbits[2] <= emt_bit;
          got_c <= got_c | cfire;
          if ((got_c | cfire) == 3'b111) st <= ST_DATA;
        end
        ST_DATA: begin
          if (afire) begin
            va       <= opa_data;
            got_x[0] <= 1'b1;
          end
          if (bfire) begin
            vb       <= opb_data;
            got_x[1] <= 1'b1;
          end
          if (a_ok && b_ok) st <= ST_ADD;
        end
        ST_ADD: begin
          acc   <= acc + va + vb;
          va    <= '0;
          vb    <= '0;
          got_c <= '0;
          got_x <= '0;
          st    <= cbits[2] ? ST_SEND : ST_CTRL;
        end
        default: begin
          if (rfire) st <= ST_CTRL;
        end
      endcase
    end
  end

  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));

  a_r7_single_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !res_valid);

  a_r5_ctrl_before_data: assert property (@(posedge clk) disable iff (!rst_n)
    (opa_ready || opb_ready) |-> !(tka_ready || tkb_ready || emt_ready));

  a_r6_sum_only_in_add: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_ADD) |=> $stable(acc));

  a_r8_no_ctrl_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(tka_ready || tkb_ready || emt_ready));

endmodule

// File: tb/test_cond_accum.sv
`timescale 1ns/1ps
module test_cond_accum;
  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] cv = '0, cd = '0;
  logic [2:0] cr;
  logic av = 0, bv = 0, sr = 1;
  logic [7:0] ad = '0, bd = '0;
  logic ar, br, sv;
  logic [7:0] sd;

  int checks = 0, fails = 0, ncyc = 0;
  logic [7:0] model = '0;

  always #10 clk = ~clk;

  cond_accum #(.WIDTH(8)) i_cond_accum (
    .clk(clk), .rst_n(rst_n),
    .tka_valid(cv[0]), .tka_ready(cr[0]), .tka_bit(cd[0]),
    .tkb_valid(cv[1]), .tkb_ready(cr[1]), .tkb_bit(cd[1]),
    .emt_valid(cv[2]), .emt_ready(cr[2]), .emt_bit(cd[2]),
    .opa_valid(av), .opa_ready(ar), .opa_data(ad),
    .opb_valid(bv), .opb_ready(br), .opb_data(bd),
    .res_valid(sv), .res_ready(sr), .res_data(sd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      fails++;
      $display("FAIL watchdog (all) actual=%0d expected=%0d", ncyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_iter(input bit c1, input bit c2, input bit c3,
                          input logic [7:0] a, input logic [7:0] b,
                          input int dc1, input int dc3, input int dx1, input int dx2,
                          input int bp);
    bit [2:0] cdone = '0;
    bit [1:0] xdone = '0;
    int cyc = 0, after = 0, outs = 0, bpl = bp;
    logic [7:0] outv = '0;
    bit seen_a = 0, seen_b = 0, bad_order = 0, bad_bp = 0, tmo = 0;
    cd = {c3, c2, c1};
    ad = c1 ? a : 8'hA5;
    bd = c2 ? b : 8'h5A;
    model = model + (c1 ? a : 8'd0) + (c2 ? b : 8'd0);
    while (1) begin
      @(negedge clk);
      cv[0] = !cdone[0] && cyc >= dc1;
      cv[1] = !cdone[1];
      cv[2] = !cdone[2] && cyc >= dc3;
      av = c1 ? (!xdone[0] && cyc >= dx1) : 1'b1;
      bv = c2 ? (!xdone[1] && cyc >= dx2) : 1'b1;
      sr = (bpl == 0);
      if (!c1 && ar) seen_a = 1;
      if (!c2 && br) seen_b = 1;
      if ((ar || br) && cdone != 3'b111) bad_order = 1;
      if (sv) begin
        if (bpl > 0) begin
          bpl--;
          if (|cr) bad_bp = 1;
        end else begin
          outs++;
          outv = sd;
        end
      end
      cdone = cdone | (cv & cr);
      if (c1 && av && ar) xdone[0] = 1;
      if (c2 && bv && br) xdone[1] = 1;
      if (cdone == 3'b111 && (!c1 || xdone[0]) && (!c2 || xdone[1])) after++;
      cyc++;
      if (c3 ? (outs >= 1) : (after >= 5)) break;
      if (cyc > 300) begin tmo = 1; break; end
    end
    @(negedge clk);
    cv = '0; av = 0; bv = 0; sr = 1;
    chk(!tmo, "R2 pass completes", cyc, 300);
    if (c3) chk(outs == 1 && outv == model, "R6/R7 emitted sum", outv, model);
    else    chk(outs == 0, "R7 no result when emit=0", outs, 0);
    if (!c1) chk(!seen_a, "R3 operand A untouched", seen_a, 0);
    if (!c2) chk(!seen_b, "R4 operand B untouched", seen_b, 0);
    chk(!bad_order, "R5 operands after controls", bad_order, 0);
    if (bp > 0) chk(!bad_bp, "R8 no control taken while result stalled", bad_bp, 0);
  endtask

  typedef struct packed {
    logic c1, c2, c3;
    logic [7:0] a, b;
    logic [1:0] dc1, dc3, dx1, dx2;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{1'b1, 1'b1, 1'b1, 8'd3,   8'd4,   2'd0, 2'd0, 2'd0, 2'd0},
    '{1'b1, 1'b0, 1'b1, 8'd10,  8'd99,  2'd2, 2'd0, 2'd0, 2'd0},
    '{1'b0, 1'b1, 1'b1, 8'd77,  8'd20,  2'd0, 2'd3, 2'd0, 2'd2},
    '{1'b0, 1'b0, 1'b1, 8'd50,  8'd50,  2'd1, 2'd1, 2'd0, 2'd0},
    '{1'b1, 1'b1, 1'b0, 8'd5,   8'd6,   2'd3, 2'd0, 2'd3, 2'd0},
    '{1'b1, 1'b1, 1'b1, 8'd1,   8'd2,   2'd0, 2'd2, 2'd0, 2'd3},
    '{1'b0, 1'b0, 1'b0, 8'd9,   8'd9,   2'd0, 2'd0, 2'd0, 2'd0},
    '{1'b1, 1'b0, 1'b0, 8'd40,  8'd13,  2'd1, 2'd0, 2'd1, 2'd0},
    '{1'b0, 1'b1, 1'b1, 8'd8,   8'd60,  2'd0, 2'd1, 2'd0, 2'd1},
    '{1'b1, 1'b1, 1'b1, 8'd200, 8'd100, 2'd2, 2'd1, 2'd2, 2'd0},
    '{1'b1, 1'b1, 1'b1, 8'd255, 8'd255, 2'd0, 2'd0, 2'd1, 2'd2},
    '{1'b0, 1'b1, 1'b0, 8'd3,   8'd17,  2'd3, 2'd3, 2'd0, 2'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cr == 3'b111, "R1 control readies after reset", cr, 7);
    chk(!ar && !br, "R1 operand readies after reset", {ar, br}, 0);
    chk(!sv, "R1 res_valid after reset", sv, 0);

    for (int i = 0; i < 12; i++)
      run_iter(TBL[i].c1, TBL[i].c2, TBL[i].c3, TBL[i].a, TBL[i].b,
               TBL[i].dc1, TBL[i].dc3, TBL[i].dx1, TBL[i].dx2, 0);

    // R8 backpressure on the result
    run_iter(1, 1, 1, 8'd3, 8'd4, 0, 0, 0, 0, 6);

    // R1 reset mid-run clears the sum
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model = '0;
    run_iter(1, 0, 1, 8'd9, 8'd0, 0, 0, 0, 0, 0);
    chk(model == 8'd9, "R1 sum restarts from zero", model, 9);

    // R6 wrap across two passes
    run_iter(1, 1, 1, 8'd250, 8'd10, 1, 0, 0, 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule